// File: doc/BRIEF.md
# Three-Level Sinusoidal PWM Generator

This block turns three signed modulating references, one per phase, into gate patterns for a three-phase, three-level neutral-point-clamped inverter. An internal up/down counter forms a symmetric triangular carrier. Two carriers are derived from it. The upper carrier spans zero to positive full scale, and the lower carrier spans negative full scale to zero. Both move in phase. Each reference is compared against both carriers to choose a ternary leg state, and each state is encoded into a fixed pattern for the four series switches of that leg.

A reference is captured once per carrier period, at the carrier peak, so a reference update arriving mid-period has no effect until the next period. While the enable input is low, or reset is high, every gate output is low. In that condition the carrier is held at zero and each held reference follows its input, so switching restarts cleanly from the carrier valley when the block is enabled. With a 25 MHz logic clock and a 5.5 kHz switching frequency, the carrier has 2272 counts per half period.

Top module: `spwm3_gen`

## Requirements
- R1: When `rst` is high or `en` is low at a clock edge, all twelve gate outputs are low after that edge.
- R2: A leg in the positive state drives its gate bus as 4'b1100. Bit 3 is the outermost upper switch and bit 0 is the outermost lower switch.
- R3: A leg in the neutral-clamped state drives its gate bus as 4'b0110.
- R4: A leg in the negative state drives its gate bus as 4'b0011.
- R5: The carrier count c steps by one per enabled cycle through 0, 1, ..., H, H-1, ..., 1 and then repeats. H = floor(round(CLK_HZ/SW_HZ)/2), so the period is 2H cycles.
- R6: The first enabled edge after `en` was low uses c = 0, and every gate output is registered, so it reflects the count of the previous edge.
- R7: A leg is positive when its held reference r satisfies r*H > c*32767, meaning the reference exceeds the upper carrier.
- R8: A leg is negative when r*H < c*32767 - 32767*H, meaning the reference is below the lower carrier. Otherwise the leg is neutral-clamped.
- R9: Each held reference is loaded from its input at the edge where c = H, and on every disabled or reset edge. At all other edges it is unchanged.
- R10: The three phases share one carrier and are otherwise independent of one another.
- R11: A zero reference keeps the leg neutral-clamped. A reference of +32767 is positive for every count except c = H. A reference of -32768 is negative on every count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous enable; low forces gates low and restarts the carrier |
| ref_a | input | 16 | Phase a modulating reference, signed two's complement |
| ref_b | input | 16 | Phase b modulating reference, signed two's complement |
| ref_c | input | 16 | Phase c modulating reference, signed two's complement |
| gate_a | output | 4 | Phase a switch pattern, bit 3 outermost upper switch |
| gate_b | output | 4 | Phase b switch pattern |
| gate_c | output | 4 | Phase c switch pattern |

## Verification
On every cycle, the assertions check four things. Disabling clears the gates. Enabled gates only take the three legal patterns. The carrier stays in range and moves by exactly one count. Held references change only at the peak or while disabled, and no leg is ever positive right after the peak. The bench's scenarios are needed for the behaviour that depends on values, not on shape. That covers the exact comparison thresholds and duty counts per period, the full-scale extremes, the deferral of a mid-period reference change, and the restart from the carrier valley.

// File: rtl/spwm3_pkg.sv
package spwm3_pkg;

    localparam int REF_W      = 16;
    localparam int FULL_SCALE = 32767;
    localparam int NUM_PH     = 3;

    typedef logic signed [REF_W-1:0] ref_t;
    typedef logic [3:0]              gate_t;

    typedef enum logic [1:0] {
        LVL_ZERO = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b10
    } lvl_t;

    typedef struct packed {
        lvl_t  lvl;
        gate_t gate;
    } leg_t;

    localparam gate_t GATE_POS  = 4'b1100;
    localparam gate_t GATE_ZERO = 4'b0110;
    localparam gate_t GATE_NEG  = 4'b0011;
    localparam gate_t GATE_OFF  = 4'b0000;

    function automatic gate_t lvl_to_gate(input lvl_t lvl);
        gate_t g;
        case (lvl)
            LVL_POS:  g = GATE_POS;
            LVL_NEG:  g = GATE_NEG;
            default:  g = GATE_ZERO;
        endcase
        return g;
    endfunction

    function automatic int half_counts(input int clk_hz, input int sw_hz);
        int period;
        period = (clk_hz + sw_hz / 2) / sw_hz;
        return period / 2;
    endfunction

endpackage

// File: rtl/spwm3_carrier.sv
module spwm3_carrier #(
    parameter int HALF = 2272,
    parameter int CW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          peak
);
    localparam logic [CW-1:0] TOP = CW'(HALF);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic rising;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            rising <= 1'b1;
        end else if (rising) begin
            cnt <= cnt + ONE;
            if (cnt + ONE == TOP) begin
                rising <= 1'b0;
            end
        end else begin
            cnt <= cnt - ONE;
            if (cnt == ONE) begin
                rising <= 1'b1;
            end
        end
    end

    assign peak = (cnt == TOP);

endmodule

// File: rtl/spwm3_leg.sv
module spwm3_leg
    import spwm3_pkg::*;
#(
    parameter int HALF = 2272,
    parameter int CW   = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic          peak,
    input  ref_t          ref_in,
    output ref_t          ref_hold,
    output gate_t         gate
);
    localparam int PW = REF_W + CW + 3;
    localparam logic signed [PW-1:0] K_HALF  = PW'(HALF);
    localparam logic signed [PW-1:0] K_FS    = PW'(FULL_SCALE);
    localparam logic signed [PW-1:0] K_SHIFT = PW'(FULL_SCALE) * PW'(HALF);

    logic signed [PW-1:0] scaled_ref;
    logic signed [PW-1:0] upper_car;
    logic signed [PW-1:0] lower_car;
    leg_t                 next_leg;

    always_comb begin
        scaled_ref = PW'(ref_hold) * K_HALF;
        upper_car  = PW'($signed({1'b0, cnt})) * K_FS;
        lower_car  = upper_car - K_SHIFT;
        if (scaled_ref > upper_car) begin
            next_leg.lvl = LVL_POS;
        end else if (scaled_ref < lower_car) begin
            next_leg.lvl = LVL_NEG;
        end else begin
            next_leg.lvl = LVL_ZERO;
        end
        next_leg.gate = lvl_to_gate(next_leg.lvl);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gate     <= GATE_OFF;
            ref_hold <= ref_in;
        end else begin
            gate <= next_leg.gate;
            if (peak) begin
                ref_hold <= ref_in;
            end
        end
    end

endmodule

// File: rtl/spwm3_gen.sv
module spwm3_gen
    import spwm3_pkg::*;
#(
    parameter int CLK_HZ = 25_000_000,
    parameter int SW_HZ  = 5_500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic signed [15:0] ref_a,
    input  logic signed [15:0] ref_b,
    input  logic signed [15:0] ref_c,
    output logic [3:0]        gate_a,
    output logic [3:0]        gate_b,
    output logic [3:0]        gate_c
);
    localparam int HALF = half_counts(CLK_HZ, SW_HZ);
    localparam int CW   = $clog2(HALF + 1);

    logic [CW-1:0] car_cnt;
    logic          car_peak;
    ref_t          ref_vec  [NUM_PH];
    ref_t          ref_hold [NUM_PH];
    gate_t         gate_vec [NUM_PH];

    assign ref_vec[0] = ref_a;
    assign ref_vec[1] = ref_b;
    assign ref_vec[2] = ref_c;

    spwm3_carrier #(.HALF(HALF), .CW(CW)) u_carrier (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cnt  (car_cnt),
        .peak (car_peak)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        spwm3_leg #(.HALF(HALF), .CW(CW)) u_leg (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .cnt      (car_cnt),
            .peak     (car_peak),
            .ref_in   (ref_vec[p]),
            .ref_hold (ref_hold[p]),
            .gate     (gate_vec[p])
        );
    end

    assign gate_a = gate_vec[0];
    assign gate_b = gate_vec[1];
    assign gate_c = gate_vec[2];

endmodule

// File: rtl/spwm3_chk.sv
module spwm3_chk #(
    parameter int HALF = 2272,
    parameter int CW   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [3:0]        gate_a,
    input logic [3:0]        gate_b,
    input logic [3:0]        gate_c,
    input logic [CW-1:0]     cnt,
    input logic              peak,
    input logic signed [15:0] hold_a,
    input logic signed [15:0] hold_b,
    input logic signed [15:0] hold_c
);
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate_a == 4'b0000 && gate_b == 4'b0000 && gate_c == 4'b0000)); // R1

    AST_LEGAL_A: assert property (@(posedge clk) disable iff (rst)
        en |=> (gate_a == 4'b1100 || gate_a == 4'b0110 || gate_a == 4'b0011)); // R2
    AST_LEGAL_B: assert property (@(posedge clk) disable iff (rst)
        en |=> (gate_b == 4'b1100 || gate_b == 4'b0110 || gate_b == 4'b0011)); // R3
    AST_LEGAL_C: assert property (@(posedge clk) disable iff (rst)
        en |=> (gate_c == 4'b1100 || gate_c == 4'b0110 || gate_c == 4'b0011)); // R4

    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(HALF)); // R5
    AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (rst)
        en |=> (!en || cnt == $past(cnt) + CW'(1) || cnt == $past(cnt) - CW'(1))); // R5

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0)); // R6

    AST_PEAK_NOT_POS: assert property (@(posedge clk) disable iff (rst)
        (en && peak) |=> (gate_a != 4'b1100 && gate_b != 4'b1100 && gate_c != 4'b1100)); // R7

    AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
        (en && !peak) |=> $stable(hold_a)); // R9
    AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
        (en && !peak) |=> $stable(hold_b)); // R9
    AST_HOLD_C: assert property (@(posedge clk) disable iff (rst)
        (en && !peak) |=> $stable(hold_c)); // R9

endmodule

bind spwm3_gen spwm3_chk #(.HALF(HALF), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .gate_a (gate_a),
    .gate_b (gate_b),
    .gate_c (gate_c),
    .cnt    (car_cnt),
    .peak   (car_peak),
    .hold_a (ref_hold[0]),
    .hold_b (ref_hold[1]),
    .hold_c (ref_hold[2])
);

// File: tb/tb_spwm3_gen.sv
module tb_spwm3_gen;

    localparam int TB_CLK = 1000;
    localparam int TB_SW  = 100;
    localparam int H      = 5;      // round(1000/100)=10, half = 5
    localparam int FS     = 32767;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic signed [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic [3:0]        gate_a, gate_b, gate_c;

    int n_checks = 0;
    int n_fail   = 0;
    int pos_cnt [3];
    int neg_cnt [3];
    int zero_cnt[3];

    // bench reference model state
    int mpos = 0;
    logic signed [15:0] mref [3];

    always #5 clk = ~clk;

    spwm3_gen #(.CLK_HZ(TB_CLK), .SW_HZ(TB_SW)) dut (
        .clk(clk), .rst(rst), .en(en),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
    );

    function automatic int tri_at(input int n);
        int m;
        m = n % (2 * H);
        return (m <= H) ? m : 2 * H - m;
    endfunction

    function automatic int state_of(input int c, input logic signed [15:0] r);
        longint lr, lc;
        lr = longint'(r);
        lc = longint'(c);
        if (lr * H > lc * FS) return 1;
        if (lr * H < lc * FS - longint'(FS) * H) return -1;
        return 0;
    endfunction

    function automatic logic [3:0] pat_of(input int s);
        if (s == 1)  return 4'b1100; // R2
        if (s == -1) return 4'b0011; // R4
        return 4'b0110;              // R3
    endfunction

    function automatic string enc_tag(input logic [3:0] e);
        if (e == 4'b1100) return "R2";
        if (e == 4'b0011) return "R4";
        if (e == 4'b0110) return "R3";
        return "R1";
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge; model the expected outputs from the inputs seen there
    task automatic step(input string req);
        logic [3:0] exp [3];
        logic signed [15:0] inr [3];
        logic [3:0] act [3];
        inr[0] = ref_a; inr[1] = ref_b; inr[2] = ref_c;
        @(posedge clk);
        if (rst || !en) begin
            for (int i = 0; i < 3; i++) begin
                exp[i]  = 4'b0000;
                mref[i] = inr[i];
            end
            mpos = 0;
        end else begin
            int c;
            c = tri_at(mpos);
            for (int i = 0; i < 3; i++) begin
                exp[i] = pat_of(state_of(c, mref[i]));
                if (c == H) mref[i] = inr[i];
            end
            mpos = (mpos + 1) % (2 * H);
        end
        #1;
        act[0] = gate_a; act[1] = gate_b; act[2] = gate_c;
        for (int i = 0; i < 3; i++) begin
            check({req, "/", enc_tag(exp[i])}, act[i], exp[i]);
            if (act[i] == 4'b1100) pos_cnt[i]++;
            if (act[i] == 4'b0011) neg_cnt[i]++;
            if (act[i] == 4'b0110) zero_cnt[i]++;
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 3; i++) begin
            pos_cnt[i] = 0; neg_cnt[i] = 0; zero_cnt[i] = 0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b1;
        ref_a = 16'sd30000; ref_b = -16'sd30000; ref_c = 16'sd100;
        for (int k = 0; k < 3; k++) step("R1");
        check("R1", gate_a | gate_b | gate_c, 4'b0000);
        rst = 1'b0; en = 1'b0;
        step("R1");
    endtask

    task automatic t_half_scale();
        en = 1'b0;
        ref_a = 16'sd16384; ref_b = -16'sd16384; ref_c = 16'sd0;
        step("R1");
        en = 1'b1;
        step("R6");
        check("R6", gate_a, 4'b1100);
        clear_counts();
        for (int k = 0; k < 10; k++) step("R7");
        check_int("R5 pos duty a", pos_cnt[0], 5);
        check_int("R8 neg duty b", neg_cnt[1], 5);
        check_int("R11 zero ref c", zero_cnt[2], 10);
        clear_counts();
        for (int k = 0; k < 10; k++) step("R8");
        check_int("R5 period repeat a", pos_cnt[0], 5);
    endtask

    task automatic t_extremes();
        en = 1'b0;
        ref_a = 16'sd32767; ref_b = -16'sd32768; ref_c = -16'sd32767;
        step("R1");
        en = 1'b1;
        clear_counts();
        for (int k = 0; k < 10; k++) step("R11");
        check_int("R11 +full a", pos_cnt[0], 9);
        check_int("R11 min b", neg_cnt[1], 10);
        check_int("R8 -full c", neg_cnt[2], 9);
    endtask

    task automatic t_sample();
        en = 1'b0;
        ref_a = 16'sd0; ref_b = 16'sd0; ref_c = 16'sd0;
        step("R1");
        en = 1'b1;
        step("R9"); step("R9");
        ref_a = 16'sd32767;
        step("R9");
        check("R9 mid-period change held off", gate_a, 4'b0110);
        for (int k = 0; k < 3; k++) step("R9");
        check("R9 held until peak", gate_a, 4'b0110);
        step("R9");
        check("R9 new value after peak", gate_a, 4'b1100);
        for (int k = 0; k < 8; k++) step("R9");
    endtask

    task automatic t_restart();
        en = 1'b1;
        ref_a = 16'sd20000; ref_b = -16'sd5000; ref_c = 16'sd8000;
        for (int k = 0; k < 13; k++) step("R10");
        en = 1'b0;
        step("R1");
        check("R1 disable clears a", gate_a, 4'b0000);
        step("R1");
        en = 1'b1;
        step("R6");
        check("R6 restart at valley c", gate_c, 4'b1100);
        for (int k = 0; k < 4; k++) step("R6");
        check("R6 restart phase b", gate_b, 4'b0110);
    endtask

    task automatic t_phases();
        en = 1'b0;
        ref_a = 16'sd25000; ref_b = -16'sd12000; ref_c = -16'sd25000;
        step("R1");
        en = 1'b1;
        clear_counts();
        for (int k = 0; k < 10; k++) step("R10");
        check_int("R10 a pos", pos_cnt[0], 7);
        check_int("R10 b neg", neg_cnt[1], 3);
        check_int("R10 c neg", neg_cnt[2], 7);
        ref_a = -16'sd3000; ref_b = 16'sd31000; ref_c = 16'sd1;
        for (int k = 0; k < 25; k++) step("R10");
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) mref[i] = '0;
        #2;
        t_reset();
        t_half_scale();
        t_extremes();
        t_sample();
        t_restart();
        t_phases();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule